// File: doc/BRIEF.md
# Clock Mode Decoder and Ratio Divider

This block sits behind a clock synthesizer and turns a three-bit frequency select plus a spread-disable input into an operating mode. From that mode it derives every clock output by integer division of one fast input clock. A 100/66 select bit picks a processor-to-bus ratio of 2 or 3. The two lower select bits pick normal running, a test mode, or a reserved code. An all-zero code withdraws the output enable so the pad drivers float.

The input `clk` is a half-period tick. Each rising edge of `clk` marks one half period of the fastest generated waveform. In normal modes the processor output toggles on every tick, so its period is 2 ticks. In the test mode `clk` ticks at twice the external test clock rate, so the test clock itself has a period of 2 ticks. All generated outputs are registered levels. They start together, so their rising edges line up.

A change of select code is captured in a register on each tick. It is applied only at the tick edge that closes a frame. A frame is the period of the slowest running output, so no output period is ever cut short. The reference and USB outputs pass the `ref_in` and `usb_in` levels through in normal and reserved modes.

Top module: `clk_mode_divider`

## Requirements
- R1: With select code 000 active, `out_en` is low and every clock output, `mode_illegal` and `downspread` are low, whatever `spread_n` is. This is also the state after reset.
- R2: In code 011 (bit 2 = 0: ratio 2), `cpu_clk` has a period of 2 ticks and `bus_clk` has a period of 4 ticks, each high for the first half of its period.
- R3: In code 111 (bit 2 = 1: ratio 3), `cpu_clk` has a period of 2 ticks and `bus_clk` has a period of 6 ticks, high for 3 ticks and low for 3 ticks.
- R4: `downspread` equals the inverse of `spread_n` in codes 011 and 111. In every other code it is low and `spread_n` has no effect.
- R5: Every rising edge of `bus_clk` and of the divided `aux_clk` falls on a tick where `cpu_clk` also rises.
- R6: With `AUX_HALF_BUS` = 1 (default), `aux_clk` in codes 011 and 111 runs at half the bus rate: a period of 8 or 12 ticks. With `AUX_HALF_BUS` = 0 it carries `ref_in`.
- R7: In reserved codes 001, 010, 101 and 110, `cpu_clk` and `bus_clk` are low and `mode_illegal` and `out_en` are high. `ref_clk` follows `ref_in` and `usb_clk` follows `usb_in`. `aux_clk` is low when `AUX_HALF_BUS` = 1 and follows `ref_in` otherwise.
- R8: In code 100 (test), the periods in ticks are: `ref_clk` 2 (the test clock), `cpu_clk` 4, `usb_clk` 4, `bus_clk` 12, and `aux_clk` 24 when `AUX_HALF_BUS` = 1 (2 otherwise). `mode_illegal` is low.
- R9: The select inputs are registered once per tick. A new mode starts on the first tick edge that both ends a frame and sees the registered new code. Its first tick has all generated outputs high. Every output period before the switch is complete.
- R10: In codes 011 and 111, `ref_clk` follows `ref_in` and `usb_clk` follows `usb_in`, and `mode_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period tick: processor rate x2 in normal modes, test clock x2 in test mode |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel | input | 3 | Frequency select; bit 2 is the 100/66 select, bits 1:0 the mode bits |
| spread_n | input | 1 | Low requests downspread in normal modes |
| ref_in | input | 1 | Reference oscillator level for pass-through |
| usb_in | input | 1 | 48 MHz source level for pass-through |
| cpu_clk | output | 1 | Processor clock output |
| bus_clk | output | 1 | Bus clock output |
| aux_clk | output | 1 | Auxiliary clock output |
| usb_clk | output | 1 | USB clock output |
| ref_clk | output | 1 | Reference clock output |
| out_en | output | 1 | Output-enable for the pad drivers; low floats all outputs |
| mode_illegal | output | 1 | High while a reserved code is active |
| downspread | output | 1 | Downspread request to the synthesizer |

## Verification
The hardest situation to reach is a select change that arrives at a chosen tick inside a running frame. It is especially hard when the change lands on the last tick, where the one-tick capture register makes the switch miss the current frame boundary and wait a whole frame more. The bench first locks onto the frame start by watching for a rising edge of the slowest output. It then counts ticks from that edge and changes the code at tick 3 of a 12-tick frame, and at tick 23 of a 24-tick frame. It predicts the switch at tick 12 and tick 48 respectively, and checks every tick on both sides of the switch.

// File: rtl/clkmode_pkg.sv
// Shared types for the clock mode decoder and ratio divider.
// Assumes: one divider per generated waveform, indexed by the constants below.
package clkmode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_TEST = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  ratio3;   // bus = cpu / 3 when set, cpu / 2 otherwise
        logic  spread;   // downspread requested
    } cfg_t;

    localparam int DIV_CPU = 0;
    localparam int DIV_BUS = 1;
    localparam int DIV_AUX = 2;
    localparam int DIV_TCK = 3;
    localparam int NDIV    = 4;

endpackage

// File: rtl/clk_mode_decoder.sv
// Decodes the three-bit frequency select and spread input into a mode record.
// Assumes: inputs are already registered in the tick domain.
module clk_mode_decoder
    import clkmode_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       spread_n,
    output cfg_t       cfg
);

    // Map each select code to a mode; the spread bit counts only in run codes.
    always_comb begin
        cfg.mode   = MODE_RSVD;
        cfg.ratio3 = 1'b0;
        cfg.spread = 1'b0;
        case (sel)
            3'b000: cfg.mode = MODE_OFF;
            3'b011, 3'b111: begin
                cfg.mode   = MODE_RUN;
                cfg.ratio3 = sel[2];
                cfg.spread = ~spread_n;
            end
            3'b100: cfg.mode = MODE_TEST;
            default: cfg.mode = MODE_RSVD;
        endcase
    end

endmodule

// File: rtl/clk_div_plan.sv
// Turns a mode record into the half-period, in ticks, of every divider.
// A half-period of zero parks that divider low.
// Assumes: a tick is a half period of the processor clock (run) or test clock (test).
module clk_div_plan
    import clkmode_pkg::*;
#(
    parameter int RATIO_LO     = 2,
    parameter int RATIO_HI     = 3,
    parameter int CPU_TEST_DIV = 2,
    parameter int BUS_TEST_DIV = 6,
    parameter int AUX_TEST_DIV = 12,
    parameter int AUX_HALF_BUS = 1,
    parameter int HW           = 5
) (
    input  cfg_t                     cfg,
    output logic [NDIV-1:0][HW-1:0]  half
);

    localparam logic [HW-1:0] H_ONE    = HW'(1);
    localparam logic [HW-1:0] H_BUS_LO = HW'(RATIO_LO);
    localparam logic [HW-1:0] H_BUS_HI = HW'(RATIO_HI);
    localparam logic [HW-1:0] H_AUX_LO = HW'(2 * RATIO_LO);
    localparam logic [HW-1:0] H_AUX_HI = HW'(2 * RATIO_HI);
    localparam logic [HW-1:0] H_T_CPU  = HW'(CPU_TEST_DIV);
    localparam logic [HW-1:0] H_T_BUS  = HW'(BUS_TEST_DIV);
    localparam logic [HW-1:0] H_T_AUX  = HW'(AUX_TEST_DIV);

    // Pick per-divider half-periods for the requested mode.
    always_comb begin
        half = '0;
        case (cfg.mode)
            MODE_RUN: begin
                half[DIV_CPU] = H_ONE;
                half[DIV_BUS] = cfg.ratio3 ? H_BUS_HI : H_BUS_LO;
                if (AUX_HALF_BUS != 0)
                    half[DIV_AUX] = cfg.ratio3 ? H_AUX_HI : H_AUX_LO;
            end
            MODE_TEST: begin
                half[DIV_CPU] = H_T_CPU;
                half[DIV_BUS] = H_T_BUS;
                half[DIV_AUX] = (AUX_HALF_BUS != 0) ? H_T_AUX : H_ONE;
                half[DIV_TCK] = H_ONE;
            end
            default: half = '0;
        endcase
    end

endmodule

// File: rtl/clk_half_divider.sv
// Generates a 50% duty waveform whose high and low phases each last `half` ticks.
// The waveform is high on count zero; at_end flags the last tick of a period.
// Assumes: restart is raised only when the whole bank sits at a period end.
module clk_half_divider #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [HW-1:0] half_new,
    output logic          wave,
    output logic          at_end
);

    localparam int CW = HW + 1;

    logic [HW-1:0] half_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] cnt_inc;

    assign last_cnt = {half_q, 1'b0} - CW'(1);
    assign cnt_inc  = cnt + CW'(1);
    assign at_end   = (half_q == '0) || (cnt == last_cnt);

    // Count ticks within the period and register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            cnt    <= '0;
            wave   <= 1'b0;
        end else if (restart) begin
            half_q <= half_new;
            cnt    <= '0;
            wave   <= (half_new != '0);
        end else if (half_q == '0) begin
            cnt    <= '0;
            wave   <= 1'b0;
        end else if (at_end) begin
            cnt    <= '0;
            wave   <= 1'b1;
        end else begin
            cnt    <= cnt_inc;
            wave   <= (cnt_inc < {1'b0, half_q});
        end
    end

    // R9: a period only ever begins from count zero, never part-way.
    assert_rise_at_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave) |-> (cnt == '0));

endmodule

// File: rtl/clk_mode_divider.sv
// Top level: captures the select, decodes the mode, switches it at frame ends,
// and drives the clock outputs from a bank of phase-aligned dividers.
// Assumes: clk is the half-period tick; ref_in and usb_in are free-running levels.
module clk_mode_divider
    import clkmode_pkg::*;
#(
    parameter int RATIO_LO     = 2,
    parameter int RATIO_HI     = 3,
    parameter int CPU_TEST_DIV = 2,
    parameter int BUS_TEST_DIV = 6,
    parameter int AUX_TEST_DIV = 12,
    parameter int AUX_HALF_BUS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] freq_sel,
    input  logic       spread_n,
    input  logic       ref_in,
    input  logic       usb_in,
    output logic       cpu_clk,
    output logic       bus_clk,
    output logic       aux_clk,
    output logic       usb_clk,
    output logic       ref_clk,
    output logic       out_en,
    output logic       mode_illegal,
    output logic       downspread
);

    localparam int MAX_A    = (AUX_TEST_DIV > 2 * RATIO_HI) ? AUX_TEST_DIV : 2 * RATIO_HI;
    localparam int MAX_B    = (BUS_TEST_DIV > CPU_TEST_DIV) ? BUS_TEST_DIV : CPU_TEST_DIV;
    localparam int MAX_HALF = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int HW       = $clog2(MAX_HALF + 1);

    logic [2:0]              sel_q;
    logic                    spn_q;
    cfg_t                    nxt_cfg;
    cfg_t                    act_cfg;
    logic [NDIV-1:0][HW-1:0] half_plan;
    logic [NDIV-1:0]         wave;
    logic [NDIV-1:0]         at_end;
    logic                    frame_end;
    logic                    restart;

    clk_mode_decoder u_dec (
        .sel      (sel_q),
        .spread_n (spn_q),
        .cfg      (nxt_cfg)
    );

    clk_div_plan #(
        .RATIO_LO     (RATIO_LO),
        .RATIO_HI     (RATIO_HI),
        .CPU_TEST_DIV (CPU_TEST_DIV),
        .BUS_TEST_DIV (BUS_TEST_DIV),
        .AUX_TEST_DIV (AUX_TEST_DIV),
        .AUX_HALF_BUS (AUX_HALF_BUS),
        .HW           (HW)
    ) u_plan (
        .cfg  (nxt_cfg),
        .half (half_plan)
    );

    assign frame_end = &at_end;
    assign restart   = frame_end && (nxt_cfg != act_cfg);

    genvar g;
    generate
        for (g = 0; g < NDIV; g++) begin : g_div
            clk_half_divider #(.HW(HW)) u_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .restart  (restart),
                .half_new (half_plan[g]),
                .wave     (wave[g]),
                .at_end   (at_end[g])
            );
        end
    endgenerate

    // Capture the select inputs and adopt a new mode only at a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q          <= 3'b000;
            spn_q          <= 1'b1;
            act_cfg.mode   <= MODE_OFF;
            act_cfg.ratio3 <= 1'b0;
            act_cfg.spread <= 1'b0;
        end else begin
            sel_q <= freq_sel;
            spn_q <= spread_n;
            if (restart)
                act_cfg <= nxt_cfg;
        end
    end

    // Route divider waves and pass-through levels to the outputs per mode.
    always_comb begin
        out_en       = (act_cfg.mode != MODE_OFF);
        mode_illegal = (act_cfg.mode == MODE_RSVD);
        downspread   = (act_cfg.mode == MODE_RUN) && act_cfg.spread;
        cpu_clk      = wave[DIV_CPU];
        bus_clk      = wave[DIV_BUS];
        case (act_cfg.mode)
            MODE_OFF: begin
                aux_clk = 1'b0;
                usb_clk = 1'b0;
                ref_clk = 1'b0;
            end
            MODE_TEST: begin
                aux_clk = wave[DIV_AUX];
                usb_clk = wave[DIV_CPU];
                ref_clk = wave[DIV_TCK];
            end
            MODE_RUN: begin
                aux_clk = (AUX_HALF_BUS != 0) ? wave[DIV_AUX] : ref_in;
                usb_clk = usb_in;
                ref_clk = ref_in;
            end
            default: begin
                aux_clk = (AUX_HALF_BUS != 0) ? 1'b0 : ref_in;
                usb_clk = usb_in;
                ref_clk = ref_in;
            end
        endcase
    end

    // R1: with the enable withdrawn nothing toggles and no flag is raised.
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !(cpu_clk || bus_clk || aux_clk || usb_clk || ref_clk
                      || downspread || mode_illegal));

    // R4: a spread request is only ever issued in a legal, enabled mode.
    assert_spread_legal_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        downspread |-> (out_en && !mode_illegal));

    // R5: bus edges are generated only together with processor edges.
    assert_bus_on_cpu_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> $rose(cpu_clk));

    // R7: reserved codes keep the processor and bus outputs parked low.
    assert_rsvd_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_illegal |-> (!cpu_clk && !bus_clk));

endmodule

// File: tb/clk_mode_divider_test.sv
// Scoreboard bench: driver tasks queue expected output vectors per tick,
// a monitor pops one per tick and compares it with the ports.
module clk_mode_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] freq_sel = 3'b000;
    logic       spread_n = 1'b1;
    logic       ref_in = 1'b0;
    logic       usb_in = 1'b0;
    logic       cpu_clk, bus_clk, aux_clk, usb_clk, ref_clk;
    logic       out_en, mode_illegal, downspread;

    always #5 clk = ~clk;

    clk_mode_divider uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_sel     (freq_sel),
        .spread_n     (spread_n),
        .ref_in       (ref_in),
        .usb_in       (usb_in),
        .cpu_clk      (cpu_clk),
        .bus_clk      (bus_clk),
        .aux_clk      (aux_clk),
        .usb_clk      (usb_clk),
        .ref_clk      (ref_clk),
        .out_en       (out_en),
        .mode_illegal (mode_illegal),
        .downspread   (downspread)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Mode numbers used by the model: 0 off, 1 reserved, 2 code 011, 3 code 111, 4 test.
    function automatic logic wv(int k, int p);
        return (k % p) < (p / 2);
    endfunction

    // Vector: [7] downspread [6] illegal [5] out_en [4] ref [3] usb [2] aux [1] bus [0] cpu
    function automatic logic [7:0] model(int md, int k, logic r, logic u, logic spn);
        logic [7:0] v;
        int p;
        v = '0;
        p = (md == 2) ? 4 : 6;
        case (md)
            1: v = {1'b0, 1'b1, 1'b1, r, u, 1'b0, 1'b0, 1'b0};
            2, 3: v = {~spn, 1'b0, 1'b1, r, u, wv(k, 2 * p), wv(k, p), wv(k, 2)};
            4: v = {1'b0, 1'b0, 1'b1, wv(k, 2), wv(k, 4), wv(k, 24), wv(k, 12), wv(k, 4)};
            default: v = '0;
        endcase
        return v;
    endfunction

    // Monitor: one comparison per tick, sampled after the outputs settle.
    initial begin
        logic [7:0] e;
        logic [7:0] obs;
        string      t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                obs = {downspread, mode_illegal, out_en, ref_clk, usb_clk, aux_clk, bus_clk, cpu_clk};
                checks++;
                if (obs !== e) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", t, obs, e);
                end
            end
        end
    end

    task automatic push_seg(int md, int k0, int n, string tag);
        for (int k = k0; k < k0 + n; k++) begin
            exp_q.push_back(model(md, k, ref_in, usb_in, spread_n));
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic drive(logic [2:0] s, logic spn, logic r, logic u);
        freq_sel = s;
        spread_n = spn;
        ref_in   = r;
        usb_in   = u;
    endtask

    // Find the tick where the slowest output rises together with cpu and bus.
    task automatic align(string tag, output bit ok);
        logic prev;
        ok   = 0;
        prev = aux_clk;
        for (int i = 0; i < 64 && !ok; i++) begin
            @(negedge clk);
            if (aux_clk && !prev && cpu_clk && bus_clk) ok = 1;
            prev = aux_clk;
        end
        if (!ok) begin
            checks++;
            errors++;
            $display("FAIL %s: no aligned frame start, got none expected one", tag);
        end
    endtask

    task automatic run_periodic(logic [2:0] s, logic spn, logic r, logic u,
                                int md, int n, string tag);
        bit ok;
        drive(s, spn, r, u);
        repeat (30) @(negedge clk);
        align(tag, ok);
        if (ok) push_seg(md, 1, n, tag);
        wait_drain();
    endtask

    task automatic run_static(logic [2:0] s, logic spn, logic r, logic u,
                              int md, int n, string tag);
        drive(s, spn, r, u);
        repeat (30) @(negedge clk);
        push_seg(md, 0, n, tag);
        wait_drain();
    endtask

    // Change the code at a known tick of a running frame and predict the switch.
    task automatic switch_case(int from_md, logic [2:0] to_sel, int to_md,
                               int frame, int change_at, string tag);
        bit ok;
        int start;
        align(tag, ok);
        if (ok) begin
            start = frame;
            while (start < change_at + 2) start += frame;
            push_seg(from_md, 1, start - 1, tag);
            for (int k = 0; k < 24; k++) begin
                exp_q.push_back(model(to_md, k, ref_in, usb_in, spread_n));
                tag_q.push_back(tag);
            end
            repeat (change_at) @(negedge clk);
            freq_sel = to_sel;
        end
        wait_drain();
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver: the test sequence.
    initial begin
        repeat (3) @(negedge clk);
        push_seg(0, 0, 2, "R1 during reset");
        wait_drain();
        rst_n = 1'b1;
        push_seg(0, 0, 4, "R1 after reset");
        wait_drain();

        // R2 R4 R5 R6 R10: ratio 2 with downspread requested.
        run_periodic(3'b011, 1'b0, 1'b1, 1'b0, 2, 24, "R2 R4 R5 R6 R10 code011");
        // R3 R4 R5 R6 R10: ratio 3, no spread, swapped pass-through levels.
        run_periodic(3'b111, 1'b1, 1'b0, 1'b1, 3, 24, "R3 R4 R6 R10 code111");
        run_periodic(3'b111, 1'b0, 1'b1, 1'b1, 3, 24, "R3 R4 R5 code111 spread");
        // R8 and R4: test mode ignores a spread request.
        run_periodic(3'b100, 1'b0, 1'b1, 1'b0, 4, 48, "R8 R4 test");
        // R7 and R4: reserved codes.
        run_static(3'b101, 1'b0, 1'b1, 1'b0, 1, 10, "R7 R4 code101");
        run_static(3'b010, 1'b0, 1'b0, 1'b1, 1, 10, "R7 code010");
        run_static(3'b110, 1'b1, 1'b1, 1'b1, 1, 10, "R7 code110");
        // R1 and R4: all-zero code with spread requested.
        run_static(3'b000, 1'b0, 1'b1, 1'b1, 0, 10, "R1 R4 code000");

        // R9: mid-frame change, then a change on the last tick of a frame.
        run_periodic(3'b111, 1'b1, 1'b0, 1'b0, 3, 12, "R9 setup");
        switch_case(3, 3'b100, 4, 12, 3, "R9 switch at tick 3");
        switch_case(4, 3'b111, 3, 24, 23, "R9 switch at last tick");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule